// File: doc/BRIEF.md
# Dual Potentiometer Wiper Register Bank

This block holds the register state of a two-channel digital potentiometer. It does not hold the resistor array itself. A host reaches it through a plain register port made of an address, write data, a single-cycle write strobe and registered read data. Two 8-bit wiper codes drive the tap selectors. A code of 00h selects the tap nearest the low terminal, FFh selects the tap nearest the high terminal, and the tap moves monotonically in between. A shutdown flag disconnects the arrays.

Addresses 0 and 1 are each shared by two registers. The control register's volume-select bit chooses which one is reached. When the bit is 0, the address reaches the channel's stored start-up code, which is non-volatile. Writing that code also moves the live wiper. When the bit is 1, the address reaches only the live wiper. Addresses 2h to Eh are general-purpose non-volatile bytes. The non-volatile store is modelled as flip-flops that `rst` does not clear. A busy timer stands in for the self-timed write cycle, and while it runs, wiper, control and further non-volatile writes are rejected.

`rst` models power-up. Both wipers start at 80h and the busy flag is clear. A recall timer then runs, and when it expires each wiper is loaded from its stored start-up code. No write is accepted until the recall is complete.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: While and right after `rst`: both wipers read 80h on their ports, `pot_shutdown` is 0, and the control register at address 10h reads 40h.
- R2: On the RECALL_CYCLES-th rising edge after `rst` is released, each wiper loads its stored start-up code. Every write before that edge is ignored.
- R3: When control bit 7 (VOL) is 1, a write to address 0 or 1 changes only that channel's wiper, and a read returns the wiper. The stored code is left unchanged and the busy flag does not set.
- R4: When VOL is 0, a write to address 0 or 1 stores the byte as that channel's start-up code and also loads it into that wiper. A read returns the stored code.
- R5: Addresses 2h to Eh are read/write non-volatile bytes. Their contents, and the start-up codes, survive `rst`.
- R6: The control register at 10h reads {VOL, SHDN, WIP, 5'b00000}. A write sets VOL from data bit 7 and SHDN from data bit 6, and `pot_shutdown` equals the inverse of SHDN.
- R7: An accepted non-volatile write sets WIP (bit 5 of 10h) for the WRITE_CYCLES cycles that follow it. WIP then clears.
- R8: While WIP is 1, writes to wipers, to the control register and to any non-volatile byte are ignored.
- R9: Reads of address Fh and of 11h to FFh return 00h, and writes to those addresses change nothing.
- R10: `reg_rdata` presents, one clock edge after `reg_addr`, the value addressed in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Single-cycle write strobe |
| reg_rdata | output | 8 | Registered read data |
| wiper0_code | output | 8 | Tap code of channel 0 |
| wiper1_code | output | 8 | Tap code of channel 1 |
| pot_shutdown | output | 1 | 1 when both arrays are in shutdown |

## Verification
The assertions assume that each write strobe lasts one cycle and that the address and data are valid with it. They also assume that `rst` is applied before any access, because it is the event that starts the recall window. The bench drives every access in one-cycle slots set up on the falling edge, and it starts with `rst` held. Its random phase mixes writes at control-register values that toggle VOL and SHDN, so that wiper aliasing, lockout during WIP and the unused addresses are all reached with the bank in both modes.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_POTS  = 2;
  localparam int NV_DEPTH  = 15;
  localparam int NV_AW     = $clog2(NV_DEPTH + 1);
  localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h10;
  localparam logic [DATA_W-1:0] WIPER_MID = 8'h80;
endpackage

// File: rtl/wbc_cycle_timer.sv
module wbc_cycle_timer #(
  parameter int CYCLES        = 100,
  parameter bit LOAD_ON_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= LOAD_ON_RESET ? LOADV : '0;
    else if (start)        cnt <= LOADV;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign last = (cnt == CW'(1));

  // R7
  timer_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R7
  timer_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !busy) |=> !busy);
endmodule

// File: rtl/wbc_nv_store.sv
module wbc_nv_store import wbc_pkg::*; #(
  parameter int DEPTH = NV_DEPTH,
  parameter int AW    = NV_AW,
  parameter int NP    = NUM_POTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] init_code [NP]
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;

  for (genvar i = 0; i < NP; i++) begin : g_init
    assign init_code[i] = mem[i];
  end

  // R5
  nv_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl import wbc_pkg::*; #(
  parameter int WRITE_CYCLES  = 2000,
  parameter int RECALL_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] wiper0_code,
  output logic [DATA_W-1:0] wiper1_code,
  output logic              pot_shutdown
);
  logic [DATA_W-1:0] wiper_q [NUM_POTS];
  logic [DATA_W-1:0] init_code [NUM_POTS];
  logic [DATA_W-1:0] nv_rdata, rd_next;
  logic ctl_vol, ctl_shdn;
  logic wip, wip_last, rec_busy, rec_last;
  logic in_pot, in_nv, is_ctrl, wr_ok, nv_we, vol_we, ctl_we;

  assign in_pot  = reg_addr < ADDR_W'(NUM_POTS);
  assign in_nv   = reg_addr < ADDR_W'(NV_DEPTH);
  assign is_ctrl = reg_addr == ADR_CTRL;
  assign wr_ok   = reg_we && !rec_busy && !wip;
  assign nv_we   = wr_ok && in_nv && !(in_pot && ctl_vol);
  assign vol_we  = wr_ok && in_pot && ctl_vol;
  assign ctl_we  = wr_ok && is_ctrl;

  wbc_nv_store u_store (
    .clk(clk), .rst(rst), .we(nv_we),
    .waddr(reg_addr[NV_AW-1:0]), .wdata(reg_wdata),
    .raddr(reg_addr[NV_AW-1:0]), .rdata(nv_rdata),
    .init_code(init_code)
  );

  wbc_cycle_timer #(.CYCLES(WRITE_CYCLES), .LOAD_ON_RESET(1'b0)) u_wr_timer (
    .clk(clk), .rst(rst), .start(nv_we), .busy(wip), .last(wip_last)
  );

  wbc_cycle_timer #(.CYCLES(RECALL_CYCLES), .LOAD_ON_RESET(1'b1)) u_recall_timer (
    .clk(clk), .rst(rst), .start(1'b0), .busy(rec_busy), .last(rec_last)
  );

  for (genvar i = 0; i < NUM_POTS; i++) begin : g_wiper
    always_ff @(posedge clk) begin
      if (rst)
        wiper_q[i] <= WIPER_MID;
      else if (rec_last)
        wiper_q[i] <= init_code[i];
      else if ((nv_we || vol_we) && reg_addr == ADDR_W'(i))
        wiper_q[i] <= reg_wdata;
    end

    // R2
    recall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      rec_busy |-> wiper_q[i] == WIPER_MID);
    // R8
    wiper_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (wip && reg_we && reg_addr == ADDR_W'(i)) |=> $stable(wiper_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_vol  <= 1'b0;
      ctl_shdn <= 1'b1;
    end else if (ctl_we) begin
      ctl_vol  <= reg_wdata[7];
      ctl_shdn <= reg_wdata[6];
    end
  end

  always_comb begin
    rd_next = '0;
    if (in_pot && ctl_vol)
      rd_next = wiper_q[reg_addr[0]];
    else if (in_nv)
      rd_next = nv_rdata;
    else if (is_ctrl)
      rd_next = {ctl_vol, ctl_shdn, wip, 5'b00000};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assign wiper0_code  = wiper_q[0];
  assign wiper1_code  = wiper_q[1];
  assign pot_shutdown = ~ctl_shdn;

  // R8
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wip && reg_we && is_ctrl) |=> ($stable(ctl_vol) && $stable(ctl_shdn)));
  // R2
  recall_lock_chk: assert property (@(posedge clk) disable iff (rst)
    rec_busy |-> !wip);
  // R7
  wip_end_chk: assert property (@(posedge clk) disable iff (rst)
    wip_last |=> !wip);
endmodule

// File: tb/wiper_bank_ctrl_bench.sv
module wiper_bank_ctrl_bench;
  localparam int WC = 40;
  localparam int RC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_rdata, wiper0_code, wiper1_code;
  logic pot_shutdown;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [7:0] m_mem [15];
  logic [7:0] m_wip [2];
  logic m_vol, m_shdn;
  int busy_left, rec_left;
  logic [7:0] exp_rd;

  always #4 clk = ~clk;

  wiper_bank_ctrl #(.WRITE_CYCLES(WC), .RECALL_CYCLES(RC)) u_wiper_bank_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .wiper0_code(wiper0_code),
    .wiper1_code(wiper1_code), .pot_shutdown(pot_shutdown)
  );

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a < 2 && m_vol) return m_wip[a[0]];
    if (a < 15) return m_mem[a];
    if (a == 8'h10) return {m_vol, m_shdn, (busy_left != 0), 5'b0};
    return 8'h00;
  endfunction

  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d);
    bit ok;
    reg_we = we; reg_addr = a; reg_wdata = d;
    exp_rd = rst ? 8'h00 : m_read(a);
    ok = !rst && we && rec_left == 0 && busy_left == 0;
    @(posedge clk);
    if (rst) begin
      m_wip[0] = 8'h80; m_wip[1] = 8'h80; m_vol = 0; m_shdn = 1;
      busy_left = 0; rec_left = RC;
    end else begin
      bit nvw;
      nvw = ok && a < 15 && !(a < 2 && m_vol);
      if (rec_left == 1) begin m_wip[0] = m_mem[0]; m_wip[1] = m_mem[1]; end
      if (rec_left != 0) rec_left--;
      if (nvw) begin
        m_mem[a] = d;
        if (a < 2) m_wip[a[0]] = d;
      end
      if (ok && a < 2 && m_vol) m_wip[a[0]] = d;
      if (ok && a == 8'h10) begin m_vol = d[7]; m_shdn = d[6]; end
      if (nvw) busy_left = WC;
      else if (busy_left != 0) busy_left--;
    end
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    cyc(1'b0, a, 8'h00);
    chk(tag, reg_rdata, exp_rd);
  endtask

  task automatic chk_out(input string tag);
    chk({tag, " wiper0"}, wiper0_code, m_wip[0]);
    chk({tag, " wiper1"}, wiper1_code, m_wip[1]);
    chk({tag, " shutdown"}, {7'b0, pot_shutdown}, {7'b0, ~m_shdn});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h20, 8'h00);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) cyc(1'b0, 8'h00, 8'h00);
    rst = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 15; k++) m_mem[k] = 8'h00;
    m_wip[0] = 8'h80; m_wip[1] = 8'h80; m_vol = 0; m_shdn = 1;
    busy_left = 0; rec_left = RC;
    void'($urandom(32'd4021));
    @(negedge clk);
    do_reset();
    // R1 reset values
    chk_out("R1");
    chk("R1 wiper0 mid", wiper0_code, 8'h80);
    rd("R1 ctrl reads 40h", 8'h10);
    chk("R1 ctrl fixed", reg_rdata, 8'h40);
    // R2 writes ignored during recall
    cyc(1'b1, 8'h10, 8'h80);
    rd("R2 ctrl write ignored in recall", 8'h10);
    chk("R2 ctrl still 40h", reg_rdata, 8'h40);
    idle(RC);
    chk_out("R2 after recall");
    // R4 stored code write also moves wiper
    cyc(1'b1, 8'h00, 8'h5A);
    chk("R4 wiper0 follows", wiper0_code, 8'h5A);
    // R7 WIP set
    rd("R7 wip set", 8'h10);
    chk("R7 ctrl reads 60h", reg_rdata, 8'h60);
    // R8 lockout
    cyc(1'b1, 8'h10, 8'hC0);
    cyc(1'b1, 8'h03, 8'h99);
    cyc(1'b1, 8'h01, 8'h11);
    rd("R8 ctrl unchanged", 8'h10);
    rd("R8 gp byte unchanged", 8'h03);
    chk_out("R8");
    idle(WC);
    rd("R7 wip clear", 8'h10);
    chk("R7 ctrl back to 40h", reg_rdata, 8'h40);
    rd("R4 stored code read", 8'h00);
    // R5 general purpose
    cyc(1'b1, 8'h05, 8'h33);
    idle(WC + 1);
    rd("R5 gp read", 8'h05);
    cyc(1'b1, 8'h0E, 8'hE7);
    idle(WC + 1);
    rd("R5 gp top byte", 8'h0E);
    // R6 / R3
    cyc(1'b1, 8'h10, 8'h80);
    chk_out("R6 shutdown on");
    rd("R6 ctrl 80h", 8'h10);
    cyc(1'b1, 8'h01, 8'h77);
    chk_out("R3 volatile write");
    rd("R3 ctrl no wip", 8'h10);
    rd("R3 wiper read", 8'h01);
    cyc(1'b1, 8'h10, 8'h40);
    rd("R3 stored code untouched", 8'h01);
    cyc(1'b1, 8'h10, 8'hC0);
    rd("R10 read latency wiper0", 8'h00);
    // R9 unused addresses
    cyc(1'b1, 8'h0F, 8'hFF);
    rd("R9 addr 0Fh", 8'h0F);
    cyc(1'b1, 8'hFF, 8'hFF);
    rd("R9 addr FFh", 8'hFF);
    rd("R9 addr 11h", 8'h11);
    rd("R9 ctrl unaffected", 8'h10);
    chk_out("R9");
    // R5 / R2 survive reset
    do_reset();
    chk_out("R1 second reset");
    idle(RC);
    chk_out("R2 recall of stored codes");
    chk("R2 wiper0 recalled", wiper0_code, 8'h5A);
    rd("R5 gp kept over reset", 8'h05);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [7:0] a;
      r = $urandom % 8;
      case (r)
        0, 1: a = r[7:0];
        2: a = 8'h10;
        3: a = 8'h0F;
        4: a = 8'($urandom);
        default: a = 8'(2 + $urandom % 13);
      endcase
      if ($urandom % 3 == 0) cyc(1'b1, a, 8'($urandom));
      else rd("R3 R4 R8 random read", a);
      if (n % 100 == 0) chk_out("R6 random outputs");
      if (n == 2000) begin do_reset(); idle(RC); chk_out("R2 random reset"); end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule